// File: doc/BRIEF.md
# Look-Ahead Microinstruction Function Decoder

This block sits between the control store and the execution datapath of a microprogrammed processor. While the current microinstruction executes, the function fields of its successor are already arriving from the control store. The block decodes them during that cycle and registers the results at the cycle boundary. The next instruction therefore starts with its command strobes settled, and no decode delay sits in its critical path.

Four 4-bit fields come in, each with its own role. The selector field sets how the Y-function field and the Z-function field are to be read. The Y field can be a branch selector, a normal function, an output-register number, or the upper nibble of a byte constant. The Z field can be a normal function, a nibble constant, the low half of a scratch-register address, or an input-register number. The X-function field always decodes as a normal function. Every decoded function comes out as an active-low one-hot strobe vector. A constant is driven onto an X-bus source value together with an active-low enable.

Instructions execute in repeating clicks of three cycles, named c1, c2 and c3. A single memory bit in the word maps to a different memory strobe depending on which of those cycles the instruction runs in. A clock enable freezes all state while the processor is stalled. A test input forces every output high.

Top module: `ucode_fn_lookahead`

## Requirements
- R1: While reset is asserted, every active-low strobe and enable is high, `xconst` is zero, `uaddr_lo` is zero and `phase` reads 2 (c3).
- R2: On each enabled clock edge, `fx_cmd_n` takes the value with bit `fx_nx` low and all other bits high.
- R3: `fs_nx[1:0]` selects how the Y field is read. Value 0 drives bit `fy_nx` low on `br_sel_n`. Value 1 does the same on `fy_fn_n`. Value 2 does the same on `io_wr_n`. Value 3 means byte constant. The two vectors not selected, and all three vectors in byte mode, stay all ones.
- R4: `fs_nx[3:2]` selects how the Z field is read. Value 0 drives bit `fz_nx` low on `fz_fn_n`. Value 2 sets `uaddr_lo` to `fz_nx` and drives `uaddr_vld_n` low. Value 3 drives bit `fz_nx` low on `io_rd_n`. Value 1 means nibble constant. In byte mode, no Z strobe is active, `uaddr_vld_n` is high and `uaddr_lo` is zero. `uaddr_lo` is also zero whenever it is not valid.
- R5: In byte mode, `xconst` equals {8'h00, fy_nx, fz_nx} and `xconst_byte_n` is low.
- R6: If `fs_nx[3:2]` is 1 and byte mode is not set, `xconst` equals {12'h000, fz_nx} and `xconst_nib_n` is low. With no constant mode, `xconst` is zero and both constant enables are high.
- R7: With `mem_nx` set, the registered instruction drives one strobe, chosen by its cycle. c1 (`phase` 0) drives `mem_addr_ld_n` low. c2 (`phase` 1) drives `mem_wr_n` low. c3 (`phase` 2) drives `mem_rd_x_n` low. With `mem_nx` clear, none of the three is low.
- R8: `phase` advances 0, 1, 2, 0, … on each enabled edge. The first enabled edge after reset yields 0. Every output reflects the fields that were present before the edge that registered it.
- R9: While `clk_en` is low, no output changes, whatever the field inputs do.
- R10: While `test_force` is high, every output, `xconst`, `uaddr_lo` and `phase` included, reads all ones. Once it is released, the registered values show again unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Gates every register update |
| test_force | input | 1 | Forces all outputs high |
| fs_nx | input | 4 | Selector field of the next instruction |
| fx_nx | input | 4 | X-function field of the next instruction |
| fy_nx | input | 4 | Y-function field of the next instruction |
| fz_nx | input | 4 | Z-function field of the next instruction |
| mem_nx | input | 1 | Memory bit of the next instruction |
| fx_cmd_n | output | 16 | X-function strobes, active low |
| fy_fn_n | output | 16 | Y normal-function strobes, active low |
| br_sel_n | output | 16 | Branch/dispatch selector strobes, active low |
| io_wr_n | output | 16 | Output-register load strobes, active low |
| fz_fn_n | output | 16 | Z normal-function strobes, active low |
| io_rd_n | output | 16 | Input-register read strobes, active low |
| uaddr_lo | output | 4 | Low half of the scratch-register address |
| uaddr_vld_n | output | 1 | `uaddr_lo` valid, active low |
| xconst | output | 16 | Constant value for the X bus |
| xconst_byte_n | output | 1 | Byte constant drives X, active low |
| xconst_nib_n | output | 1 | Nibble constant drives X, active low |
| mem_addr_ld_n | output | 1 | Load memory address register (c1), active low |
| mem_wr_n | output | 1 | Load write data and write memory (c2), active low |
| mem_rd_x_n | output | 1 | Put memory data on X (c3), active low |
| phase | output | 2 | Cycle within the click of the registered instruction |

## Verification
The bench builds the block with its default field width of 4 and X-bus width of 16. At these values every one of the 16 codes of each field, and all 16 selector combinations, can be reached in a short run. A directed sweep pairs each selector value with memory bits landing in all three cycles of the click. Random traffic then mixes stalls and forcing into the stream, so held and forced outputs get compared against the model as well as freshly decoded ones.

// File: rtl/ufd_pkg.sv
package ufd_pkg;

    typedef enum logic [1:0] {
        PH_C1 = 2'd0,
        PH_C2 = 2'd1,
        PH_C3 = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        FY_BRANCH = 2'd0,
        FY_NORM   = 2'd1,
        FY_IOWR   = 2'd2,
        FY_BYTE   = 2'd3
    } fy_mode_e;

    typedef enum logic [1:0] {
        FZ_NORM  = 2'd0,
        FZ_NIB   = 2'd1,
        FZ_UADDR = 2'd2,
        FZ_IORD  = 2'd3
    } fz_mode_e;

    // index of each one-hot decoder in the decoder bank
    localparam int DEC_FX   = 0;
    localparam int DEC_FYFN = 1;
    localparam int DEC_BR   = 2;
    localparam int DEC_IOW  = 3;
    localparam int DEC_FZFN = 4;
    localparam int DEC_IOR  = 5;
    localparam int NDEC     = 6;

endpackage

// File: rtl/ufd_onehot.sv
module ufd_onehot #(
    parameter int FW = 4,
    localparam int NC = 1 << FW
) (
    input  logic [FW-1:0] code,
    input  logic          en,
    output logic [NC-1:0] hot_n
);

    for (genvar i = 0; i < NC; i++) begin : g_bit
        assign hot_n[i] = ~(en && (code == FW'(i)));
    end

endmodule

// File: rtl/ufd_click_seq.sv
module ufd_click_seq
    import ufd_pkg::*;
(
    input  logic [1:0] cur,
    output logic [1:0] nxt
);

    always_comb begin
        case (cur)
            PH_C1:   nxt = PH_C2;
            PH_C2:   nxt = PH_C3;
            default: nxt = PH_C1;
        endcase
    end

endmodule

// File: rtl/ufd_const_sel.sv
module ufd_const_sel #(
    parameter int FW = 4,
    parameter int XW = 16
) (
    input  logic [FW-1:0] fy,
    input  logic [FW-1:0] fz,
    input  logic          byte_m,
    input  logic          nib_m,
    output logic [XW-1:0] value
);

    always_comb begin
        value = '0;
        if (byte_m) begin
            value[2*FW-1:0] = {fy, fz};
        end else if (nib_m) begin
            value[FW-1:0] = fz;
        end
    end

endmodule

// File: rtl/ucode_fn_lookahead.sv
module ucode_fn_lookahead
    import ufd_pkg::*;
#(
    parameter int FW = 4,
    parameter int XW = 16,
    localparam int NC = 1 << FW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          test_force,
    input  logic [FW-1:0] fs_nx,
    input  logic [FW-1:0] fx_nx,
    input  logic [FW-1:0] fy_nx,
    input  logic [FW-1:0] fz_nx,
    input  logic          mem_nx,
    output logic [NC-1:0] fx_cmd_n,
    output logic [NC-1:0] fy_fn_n,
    output logic [NC-1:0] br_sel_n,
    output logic [NC-1:0] io_wr_n,
    output logic [NC-1:0] fz_fn_n,
    output logic [NC-1:0] io_rd_n,
    output logic [FW-1:0] uaddr_lo,
    output logic          uaddr_vld_n,
    output logic [XW-1:0] xconst,
    output logic          xconst_byte_n,
    output logic          xconst_nib_n,
    output logic          mem_addr_ld_n,
    output logic          mem_wr_n,
    output logic          mem_rd_x_n,
    output logic [1:0]    phase
);

    typedef struct packed {
        logic [NDEC-1:0][NC-1:0] dec_n;
        logic [FW-1:0]           ua;
        logic                    ua_n;
        logic [XW-1:0]           xc;
        logic                    xb_n;
        logic                    xn_n;
        logic                    ma_n;
        logic                    mw_n;
        logic                    mr_n;
        logic [1:0]              ph;
    } st_t;

    localparam st_t ST_RST = '{
        dec_n: '1,
        ua:    '0,
        ua_n:  1'b1,
        xc:    '0,
        xb_n:  1'b1,
        xn_n:  1'b1,
        ma_n:  1'b1,
        mw_n:  1'b1,
        mr_n:  1'b1,
        ph:    PH_C3
    };

    st_t st_d, st_q;

    fy_mode_e fy_mode;
    fz_mode_e fz_mode;
    logic     byte_m;
    logic     nib_m;

    assign fy_mode = fy_mode_e'(fs_nx[1:0]);
    assign fz_mode = fz_mode_e'(fs_nx[3:2]);
    assign byte_m  = (fy_mode == FY_BYTE);
    assign nib_m   = !byte_m && (fz_mode == FZ_NIB);

    // decoder bank: one one-hot decoder per strobe group
    logic [NDEC-1:0][FW-1:0] dec_code;
    logic [NDEC-1:0]         dec_en;
    logic [NDEC-1:0][NC-1:0] dec_hot_n;

    always_comb begin
        dec_code           = '0;
        dec_code[DEC_FX]   = fx_nx;
        dec_code[DEC_FYFN] = fy_nx;
        dec_code[DEC_BR]   = fy_nx;
        dec_code[DEC_IOW]  = fy_nx;
        dec_code[DEC_FZFN] = fz_nx;
        dec_code[DEC_IOR]  = fz_nx;

        dec_en             = '0;
        dec_en[DEC_FX]     = 1'b1;
        dec_en[DEC_FYFN]   = (fy_mode == FY_NORM);
        dec_en[DEC_BR]     = (fy_mode == FY_BRANCH);
        dec_en[DEC_IOW]    = (fy_mode == FY_IOWR);
        dec_en[DEC_FZFN]   = !byte_m && (fz_mode == FZ_NORM);
        dec_en[DEC_IOR]    = !byte_m && (fz_mode == FZ_IORD);
    end

    for (genvar d = 0; d < NDEC; d++) begin : g_dec
        ufd_onehot #(.FW(FW)) u_dec (
            .code  (dec_code[d]),
            .en    (dec_en[d]),
            .hot_n (dec_hot_n[d])
        );
    end

    logic [1:0]    ph_nx;
    logic [XW-1:0] const_val;

    ufd_click_seq u_seq (
        .cur (st_q.ph),
        .nxt (ph_nx)
    );

    ufd_const_sel #(.FW(FW), .XW(XW)) u_const (
        .fy     (fy_nx),
        .fz     (fz_nx),
        .byte_m (byte_m),
        .nib_m  (nib_m),
        .value  (const_val)
    );

    always_comb begin
        logic ua_sel;
        ua_sel     = !byte_m && (fz_mode == FZ_UADDR);

        st_d       = st_q;
        st_d.dec_n = dec_hot_n;
        st_d.ua    = ua_sel ? fz_nx : '0;
        st_d.ua_n  = !ua_sel;
        st_d.xc    = const_val;
        st_d.xb_n  = !byte_m;
        st_d.xn_n  = !nib_m;
        st_d.ph    = ph_nx;
        st_d.ma_n  = !(mem_nx && (ph_nx == PH_C1));
        st_d.mw_n  = !(mem_nx && (ph_nx == PH_C2));
        st_d.mr_n  = !(mem_nx && (ph_nx == PH_C3));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else if (clk_en) begin
            st_q <= st_d;
        end
    end

    // test override sits after the registers and leaves state untouched
    assign fx_cmd_n      = st_q.dec_n[DEC_FX]   | {NC{test_force}};
    assign fy_fn_n       = st_q.dec_n[DEC_FYFN] | {NC{test_force}};
    assign br_sel_n      = st_q.dec_n[DEC_BR]   | {NC{test_force}};
    assign io_wr_n       = st_q.dec_n[DEC_IOW]  | {NC{test_force}};
    assign fz_fn_n       = st_q.dec_n[DEC_FZFN] | {NC{test_force}};
    assign io_rd_n       = st_q.dec_n[DEC_IOR]  | {NC{test_force}};
    assign uaddr_lo      = st_q.ua              | {FW{test_force}};
    assign uaddr_vld_n   = st_q.ua_n            | test_force;
    assign xconst        = st_q.xc              | {XW{test_force}};
    assign xconst_byte_n = st_q.xb_n            | test_force;
    assign xconst_nib_n  = st_q.xn_n            | test_force;
    assign mem_addr_ld_n = st_q.ma_n            | test_force;
    assign mem_wr_n      = st_q.mw_n            | test_force;
    assign mem_rd_x_n    = st_q.mr_n            | test_force;
    assign phase         = st_q.ph              | {2{test_force}};

endmodule

// File: rtl/ufd_chk.sv
module ufd_chk #(
    parameter int FW = 4,
    parameter int XW = 16,
    localparam int NC = 1 << FW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          test_force,
    input logic [NC-1:0] fx_cmd_n,
    input logic [NC-1:0] fy_fn_n,
    input logic [NC-1:0] br_sel_n,
    input logic [NC-1:0] io_wr_n,
    input logic [NC-1:0] fz_fn_n,
    input logic [NC-1:0] io_rd_n,
    input logic [FW-1:0] uaddr_lo,
    input logic          uaddr_vld_n,
    input logic [XW-1:0] xconst,
    input logic          xconst_byte_n,
    input logic          xconst_nib_n,
    input logic          mem_addr_ld_n,
    input logic          mem_wr_n,
    input logic          mem_rd_x_n,
    input logic [1:0]    phase
);

    a_r2_fx_onehot: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        $onehot0(~fx_cmd_n));

    a_r3_fy_single_meaning: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        $onehot0({~&fy_fn_n, ~&br_sel_n, ~&io_wr_n, ~xconst_byte_n}));

    a_r4_fz_single_meaning: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        $onehot0({~&fz_fn_n, ~&io_rd_n, ~uaddr_vld_n, ~xconst_nib_n, ~xconst_byte_n}));

    a_r4_uaddr_zero_idle: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        uaddr_vld_n |-> (uaddr_lo == '0));

    a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        !xconst_byte_n |-> (xconst[XW-1:2*FW] == '0));

    a_r6_nib_upper_zero: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        !xconst_nib_n |-> (xconst[XW-1:FW] == '0));

    a_r7_mem_by_phase: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        (!mem_addr_ld_n |-> phase == 2'd0) and
        (!mem_wr_n      |-> phase == 2'd1) and
        (!mem_rd_x_n    |-> phase == 2'd2));

    a_r8_phase_step: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        (clk_en && !test_force) |=>
        (phase == (($past(phase) == 2'd2) ? 2'd0 : $past(phase) + 2'd1)));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n || test_force)
        (!clk_en && !test_force) |=>
        ($stable(fx_cmd_n) && $stable(phase) && $stable(xconst) && $stable(mem_wr_n)));

    a_r10_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        test_force |-> (&fx_cmd_n && &fy_fn_n && &xconst && &phase && mem_wr_n && uaddr_vld_n));

endmodule

bind ucode_fn_lookahead ufd_chk #(.FW(FW), .XW(XW)) chk_i (.*);

// File: tb/ucode_fn_lookahead_tb_top.sv
module ucode_fn_lookahead_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, clk_en, test_force, mem_nx;
    logic [3:0]  fs_nx, fx_nx, fy_nx, fz_nx;
    logic [15:0] fx_cmd_n, fy_fn_n, br_sel_n, io_wr_n, fz_fn_n, io_rd_n, xconst;
    logic [3:0]  uaddr_lo;
    logic        uaddr_vld_n, xconst_byte_n, xconst_nib_n;
    logic        mem_addr_ld_n, mem_wr_n, mem_rd_x_n;
    logic [1:0]  phase;

    always #(CLK_PERIOD/2) clk = ~clk;

    ucode_fn_lookahead dut_i (.*);

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference model
    int          m_ph;
    logic [15:0] e_fx, e_fyfn, e_br, e_iow, e_fzfn, e_ior, e_xc;
    logic [3:0]  e_ua;
    logic        e_uav, e_xb, e_xn, e_ma, e_mw, e_mr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 2;
            e_fx = 16'hFFFF; e_fyfn = 16'hFFFF; e_br = 16'hFFFF; e_iow = 16'hFFFF;
            e_fzfn = 16'hFFFF; e_ior = 16'hFFFF; e_xc = 16'h0; e_ua = 4'h0;
            e_uav = 1'b1; e_xb = 1'b1; e_xn = 1'b1; e_ma = 1'b1; e_mw = 1'b1; e_mr = 1'b1;
        end else if (clk_en) begin
            int ym, zm;
            bit bm, nm;
            ym = int'(fs_nx[1:0]);
            zm = int'(fs_nx[3:2]);
            bm = (ym == 3);
            nm = !bm && (zm == 1);
            m_ph   = (m_ph + 1) % 3;
            e_fx   = ~(16'h1 << fx_nx);
            e_br   = (ym == 0) ? ~(16'h1 << fy_nx) : 16'hFFFF;
            e_fyfn = (ym == 1) ? ~(16'h1 << fy_nx) : 16'hFFFF;
            e_iow  = (ym == 2) ? ~(16'h1 << fy_nx) : 16'hFFFF;
            e_fzfn = (!bm && zm == 0) ? ~(16'h1 << fz_nx) : 16'hFFFF;
            e_ior  = (!bm && zm == 3) ? ~(16'h1 << fz_nx) : 16'hFFFF;
            e_uav  = !(!bm && zm == 2);
            e_ua   = e_uav ? 4'h0 : fz_nx;
            e_xb   = !bm;
            e_xn   = !nm;
            e_xc   = bm ? {8'h00, fy_nx, fz_nx} : (nm ? {12'h000, fz_nx} : 16'h0);
            e_ma   = !(mem_nx && m_ph == 0);
            e_mw   = !(mem_nx && m_ph == 1);
            e_mr   = !(mem_nx && m_ph == 2);
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        logic f;
        f = test_force;
        chk(f ? "R10 fx forced" : "R2 fx strobes", 32'(fx_cmd_n), 32'(e_fx | {16{f}}));
        chk(f ? "R10 fy forced" : "R3 fy groups",
            {fy_fn_n, br_sel_n}, {e_fyfn | {16{f}}, e_br | {16{f}}});
        chk(f ? "R10 iow forced" : "R3 io write", 32'(io_wr_n), 32'(e_iow | {16{f}}));
        chk(f ? "R10 fz forced" : "R4 fz groups",
            {fz_fn_n, io_rd_n}, {e_fzfn | {16{f}}, e_ior | {16{f}}});
        chk(f ? "R10 uaddr forced" : "R4 uaddr",
            {27'h0, uaddr_vld_n, uaddr_lo}, {27'h0, e_uav | f, e_ua | {4{f}}});
        chk(f ? "R10 const forced" : (!e_xb ? "R5 byte const" : "R6 nibble const"),
            {14'h0, xconst_byte_n, xconst_nib_n, xconst},
            {14'h0, e_xb | f, e_xn | f, e_xc | {16{f}}});
        chk(f ? "R10 mem forced" : "R7 mem strobes",
            {29'h0, mem_addr_ld_n, mem_wr_n, mem_rd_x_n},
            {29'h0, e_ma | f, e_mw | f, e_mr | f});
        chk(f ? "R10 phase forced" : "R8 phase", 32'(phase), 32'(2'(m_ph) | {2{f}}));
    endtask

    // compare at the falling edge, then drive the next fields
    task automatic step(input logic [3:0] s, input logic [3:0] x, input logic [3:0] y,
                        input logic [3:0] z, input logic m, input logic en, input logic tf);
        @(negedge clk);
        cmp_all();
        fs_nx = s; fx_nx = x; fy_nx = y; fz_nx = z; mem_nx = m;
        clk_en = en; test_force = tf;
    endtask

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_err++;
                n_chk++;
                $display("FAIL R8 watchdog expired act=%0d exp<=20000", cyc);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] held_fx, held_xc;
        logic [1:0]  held_ph;
        rst_n = 1'b0; clk_en = 1'b1; test_force = 1'b0;
        fs_nx = 4'h0; fx_nx = 4'h0; fy_nx = 4'h0; fz_nx = 4'h0; mem_nx = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 strobes reset", {fx_cmd_n, fy_fn_n}, 32'hFFFF_FFFF);
        chk("R1 more strobes reset", {br_sel_n & io_wr_n, fz_fn_n & io_rd_n}, 32'hFFFF_FFFF);
        chk("R1 const reset", {12'h0, uaddr_lo, xconst}, 32'h0);
        chk("R1 enables reset",
            {26'h0, uaddr_vld_n, xconst_byte_n, xconst_nib_n, mem_addr_ld_n, mem_wr_n, mem_rd_x_n},
            32'h3F);
        chk("R1 phase reset", 32'(phase), 32'd2);
        rst_n = 1'b1;

        // directed sweep of every selector value, memory bit in each click cycle
        for (int r = 0; r < 3; r++) begin
            for (int s = 0; s < 16; s++) begin
                step(4'(s), 4'(s + r), 4'(s ^ 5), 4'(~s), 1'b1, 1'b1, 1'b0);
            end
        end
        // boundary codes 0 and 15 in every field
        for (int s = 0; s < 16; s++) begin
            step(4'(s), 4'hF, 4'h0, 4'hF, 1'b0, 1'b1, 1'b0);
            step(4'(s), 4'h0, 4'hF, 4'h0, 1'b1, 1'b1, 1'b0);
        end

        // R9 explicit stall: fields change, outputs must not
        step(4'b0111, 4'h3, 4'hA, 4'h5, 1'b1, 1'b1, 1'b0);
        step(4'b0111, 4'h3, 4'hA, 4'h5, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        held_fx = fx_cmd_n; held_xc = xconst; held_ph = phase;
        fs_nx = 4'b0001; fx_nx = 4'h9; fy_nx = 4'h2; fz_nx = 4'h1;
        repeat (3) @(negedge clk);
        chk("R9 stall holds fx", 32'(fx_cmd_n), 32'(held_fx));
        chk("R9 stall holds const", 32'(xconst), 32'(held_xc));
        chk("R9 stall holds phase", 32'(phase), 32'(held_ph));
        cmp_all();

        // R10 explicit force and release
        test_force = 1'b1;
        #1;
        chk("R10 force all high", {fx_cmd_n, xconst}, 32'hFFFF_FFFF);
        chk("R10 force phase", 32'(phase), 32'd3);
        test_force = 1'b0;
        #1;
        chk("R10 release restores", {fx_cmd_n, xconst}, {held_fx, held_xc});
        clk_en = 1'b1;

        // random traffic with stalls and forcing
        for (int i = 0; i < 1500; i++) begin
            step(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
                 ($urandom % 5) != 0, ($urandom % 10) == 0);
        end
        step(4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        cmp_all();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule